// File: doc/BRIEF.md
# Multi-Source Global Trigger Generator

This block turns 64 per-channel discriminator hits, two external trigger lines and an internal periodic tick into one global trigger pulse. A mode input picks the condition that fires. The condition can be any hit, a coincidence between the lower and upper halves of the channel array, any adjacent pair hit together, a hit count reaching a programmable threshold, one of the two external inputs, or the periodic tick. A trigger fires once, on the rising edge of the selected condition.

The acquisition back-end drives a busy line. While busy is high, a new trigger edge is refused and added to an overrun count. Each accepted trigger comes out as a one-cycle pulse. With it come a trigger number and a timestamp. The timestamp is taken from a free-running counter that advances in 12.8 ns steps from a 4 ns clock.

Top module: `trig_gen`

## Requirements
- R1: After reset, `trigPulse`, `trigId`, `trigStamp` and `overrunCnt` are all zero.
- R2: Mode code 0 fires when any of `chanHit[63:0]` is high. The external inputs have no effect in this mode.
- R3: Mode code 1 fires only when at least one channel in 0..31 and at least one channel in 32..63 are high in the same cycle. Hits confined to one half do not fire.
- R4: Mode code 2 fires when both channels of some pair (2k, 2k+1) are high. Two hits in different pairs do not fire.
- R5: Mode code 3 fires when the number of high channels is greater than or equal to `majThresh`. A threshold of 0 never fires.
- R6: Mode code 4 fires on `extTrig0` and mode code 5 fires on `extTrig1`, each ignoring the channels and the other input. Mode code 7 never fires.
- R7: Mode code 6 fires once every `tickPeriod` clock cycles. A period below 4 cycles is treated as 4.
- R8: A trigger is a single-cycle `trigPulse` produced on the rising edge of the selected condition. A condition held high gives exactly one pulse. For an input sampled at clock edge k, the pulse is high after edge k+3.
- R9: A rising edge of the condition while `busy` is high gives no pulse and increases `overrunCnt` by one. Releasing `busy` while the condition stays high gives no pulse.
- R10: `trigId` takes the number of triggers accepted before the current one. The first trigger is 0, and the value changes only on accepted triggers.
- R11: An internal timestamp advances by 5 every 16 clock cycles. `trigStamp` captures it on each accepted trigger, so two triggers 32 cycles apart differ by exactly 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 4 ns period |
| rstN | input | 1 | Active-low synchronous reset |
| chanHit | input | 64 | Per-channel self-trigger levels |
| extTrig0 | input | 1 | External trigger input 0 |
| extTrig1 | input | 1 | External trigger input 1 |
| busy | input | 1 | Back-end busy; blocks new triggers |
| trigMode | input | 3 | Source select code (0..7) |
| majThresh | input | 7 | Majority threshold, 0 disables |
| tickPeriod | input | 33 | Periodic trigger period in clock cycles |
| trigPulse | output | 1 | One-cycle global trigger |
| trigId | output | 32 | Number of the latest accepted trigger |
| trigStamp | output | 56 | Timestamp latched at the latest trigger |
| overrunCnt | output | 16 | Triggers refused while busy (saturating) |

## Verification
Each channel mode gets at least one pattern that must fire and one near miss that must not. The near misses are:
- two hits in the same plane, to check the plane split at channel 32;
- hits in neighbouring but different pairs, to check the pair grouping;
- a threshold one above the hit count and a zero threshold, to check the majority compare;
- the unselected external line, to check the source mux.

Levels held for many cycles check edge detection and the fixed latency. Busy windows separate refusal from acceptance and show whether the trigger number skips refused edges. Periodic runs at periods of 10, 2 and 32 measure the pulse spacing, the lower clamp and the timestamp rate.

// File: rtl/trig_gen_pkg.sv
package trig_gen_pkg;

  typedef enum logic [2:0] {
    MODE_OR    = 3'd0,
    MODE_PLANE = 3'd1,
    MODE_PAIR  = 3'd2,
    MODE_MAJ   = 3'd3,
    MODE_EXT0  = 3'd4,
    MODE_EXT1  = 3'd5,
    MODE_TICK  = 3'd6,
    MODE_OFF   = 3'd7
  } trig_mode_e;

  typedef struct packed {
    logic accept;
    logic reject;
  } trig_strobe_t;

endpackage

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_gen_pkg::*;
#(
  parameter int NUM_CH     = 64,
  parameter int GRP        = 8,
  parameter int ID_W       = 32,
  parameter int TS_W       = 56,
  parameter int OVR_W      = 16,
  parameter int PER_W      = 33,
  parameter int MIN_PERIOD = 4,
  parameter int TS_NUM     = 5,
  parameter int TS_DEN     = 16,
  localparam int CNT_W     = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanHit,
  input  logic              extTrig0,
  input  logic              extTrig1,
  input  trig_mode_e        mode,
  input  logic [CNT_W-1:0]  majThresh,
  input  logic [PER_W-1:0]  tickPeriod,
  input  trig_strobe_t      strobe,
  output logic              cond,
  output logic              trigPulse,
  output logic [ID_W-1:0]   trigId,
  output logic [TS_W-1:0]   trigStamp,
  output logic [OVR_W-1:0]  overrunCnt
);

  localparam int NUM_GRP = NUM_CH / GRP;
  localparam int HALF    = NUM_CH / 2;
  localparam int GRP_CW  = $clog2(GRP + 1);
  localparam int ACC_W   = $clog2(TS_DEN) + 1;

  // periodic tick source
  logic [PER_W-1:0] tickCnt, perEff;
  logic             tick;
  assign perEff = (tickPeriod < PER_W'(MIN_PERIOD)) ? PER_W'(MIN_PERIOD) : tickPeriod;

  always_ff @(posedge clk) begin
    if (!rstN || mode != MODE_TICK) begin
      tickCnt <= '0;
      tick    <= 1'b0;
    end else if (tickCnt >= perEff - PER_W'(1)) begin
      tickCnt <= '0;
      tick    <= 1'b1;
    end else begin
      tickCnt <= tickCnt + PER_W'(1);
      tick    <= 1'b0;
    end
  end

  // simple combinational sources, delayed to match the adder tree
  logic [HALF-1:0] pairAnd;
  for (genvar p = 0; p < HALF; p++) begin : g_pair
    assign pairAnd[p] = chanHit[2*p] & chanHit[2*p+1];
  end

  logic fastSel, fastA, fastB;
  always_comb begin
    case (mode)
      MODE_OR:    fastSel = |chanHit;
      MODE_PLANE: fastSel = (|chanHit[HALF-1:0]) & (|chanHit[NUM_CH-1:HALF]);
      MODE_PAIR:  fastSel = |pairAnd;
      MODE_EXT0:  fastSel = extTrig0;
      MODE_EXT1:  fastSel = extTrig1;
      MODE_TICK:  fastSel = tick;
      default:    fastSel = 1'b0;
    endcase
  end

  // majority: stage 1 group popcounts, stage 2 total, stage 3 compare
  logic [GRP_CW-1:0] grpSum [NUM_GRP];
  logic [GRP_CW-1:0] grpCnt [NUM_GRP];
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    always_comb begin
      grpSum[g] = '0;
      for (int b = 0; b < GRP; b++) grpSum[g] = grpSum[g] + GRP_CW'(chanHit[g*GRP+b]);
    end
    always_ff @(posedge clk) begin
      if (!rstN) grpCnt[g] <= '0;
      else       grpCnt[g] <= grpSum[g];
    end
  end

  logic [CNT_W-1:0] totalSum, totalQ;
  always_comb begin
    totalSum = '0;
    for (int g = 0; g < NUM_GRP; g++) totalSum = totalSum + CNT_W'(grpCnt[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fastA  <= 1'b0;
      fastB  <= 1'b0;
      totalQ <= '0;
      cond   <= 1'b0;
    end else begin
      fastA  <= fastSel;
      fastB  <= fastA;
      totalQ <= totalSum;
      if (mode == MODE_MAJ) cond <= (majThresh != '0) && (totalQ >= majThresh);
      else                  cond <= fastB;
    end
  end

  // timestamp: fractional step of TS_NUM/TS_DEN per clock
  logic [ACC_W-1:0] phaseAcc, phaseSum;
  logic [TS_W-1:0]  tsCnt;
  assign phaseSum = phaseAcc + ACC_W'(TS_NUM);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseAcc <= '0;
      tsCnt    <= '0;
    end else if (phaseSum >= ACC_W'(TS_DEN)) begin
      phaseAcc <= phaseSum - ACC_W'(TS_DEN);
      tsCnt    <= tsCnt + TS_W'(1);
    end else begin
      phaseAcc <= phaseSum;
    end
  end

  // trigger outputs
  logic [ID_W-1:0] idCnt;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigPulse  <= 1'b0;
      trigId     <= '0;
      trigStamp  <= '0;
      idCnt      <= '0;
      overrunCnt <= '0;
    end else begin
      trigPulse <= strobe.accept;
      if (strobe.accept) begin
        trigId    <= idCnt;
        idCnt     <= idCnt + ID_W'(1);
        trigStamp <= tsCnt;
      end
      if (strobe.reject && overrunCnt != '1) overrunCnt <= overrunCnt + OVR_W'(1);
    end
  end

endmodule

// File: rtl/trig_control.sv
module trig_control
  import trig_gen_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cond,
  input  logic         busy,
  output trig_strobe_t strobe
);

  logic condPrev, condRise;

  always_ff @(posedge clk) begin
    if (!rstN) condPrev <= 1'b0;
    else       condPrev <= cond;
  end

  assign condRise      = cond & ~condPrev;
  assign strobe.accept = condRise & ~busy;
  assign strobe.reject = condRise & busy;

endmodule

// File: rtl/trig_gen.sv
module trig_gen
  import trig_gen_pkg::*;
#(
  parameter int NUM_CH     = 64,
  parameter int GRP        = 8,
  parameter int ID_W       = 32,
  parameter int TS_W       = 56,
  parameter int OVR_W      = 16,
  parameter int PER_W      = 33,
  parameter int MIN_PERIOD = 4,
  parameter int TS_NUM     = 5,
  parameter int TS_DEN     = 16,
  localparam int CNT_W     = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanHit,
  input  logic              extTrig0,
  input  logic              extTrig1,
  input  logic              busy,
  input  logic [2:0]        trigMode,
  input  logic [CNT_W-1:0]  majThresh,
  input  logic [PER_W-1:0]  tickPeriod,
  output logic              trigPulse,
  output logic [ID_W-1:0]   trigId,
  output logic [TS_W-1:0]   trigStamp,
  output logic [OVR_W-1:0]  overrunCnt
);

  trig_strobe_t strobe;
  logic         cond;

  trig_datapath #(
    .NUM_CH(NUM_CH), .GRP(GRP), .ID_W(ID_W), .TS_W(TS_W), .OVR_W(OVR_W),
    .PER_W(PER_W), .MIN_PERIOD(MIN_PERIOD), .TS_NUM(TS_NUM), .TS_DEN(TS_DEN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .chanHit(chanHit), .extTrig0(extTrig0), .extTrig1(extTrig1),
    .mode(trig_mode_e'(trigMode)), .majThresh(majThresh), .tickPeriod(tickPeriod),
    .strobe(strobe), .cond(cond), .trigPulse(trigPulse), .trigId(trigId),
    .trigStamp(trigStamp), .overrunCnt(overrunCnt)
  );

  trig_control u_ctl (
    .clk(clk), .rstN(rstN), .cond(cond), .busy(busy), .strobe(strobe)
  );

endmodule

// File: rtl/trig_gen_chk.sv
module trig_gen_chk #(
  parameter int ID_W  = 32,
  parameter int TS_W  = 56,
  parameter int OVR_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             trigPulse,
  input logic [ID_W-1:0]  trigId,
  input logic [TS_W-1:0]  trigStamp,
  input logic [OVR_W-1:0] overrunCnt
);

  logic [ID_W-1:0] pulsesSeen;
  always_ff @(posedge clk) begin
    if (!rstN)          pulsesSeen <= '0;
    else if (trigPulse) pulsesSeen <= pulsesSeen + ID_W'(1);
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse); // R8

  AST_NO_PULSE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> !$past(busy)); // R9

  AST_OVR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (overrunCnt == $past(overrunCnt)) || (overrunCnt == $past(overrunCnt) + OVR_W'(1))); // R9

  AST_OVR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (overrunCnt != $past(overrunCnt)) |-> !trigPulse); // R9

  AST_ID_SEQUENCE: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> (trigId == pulsesSeen)); // R10

  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !trigPulse |-> $stable(trigId)); // R10

  AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !trigPulse |-> $stable(trigStamp)); // R11

endmodule

bind trig_gen trig_gen_chk #(.ID_W(ID_W), .TS_W(TS_W), .OVR_W(OVR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .trigPulse(trigPulse),
  .trigId(trigId), .trigStamp(trigStamp), .overrunCnt(overrunCnt)
);

// File: tb/tb_trig_gen.sv
module tb_trig_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] chanHit = '0;
  logic        extTrig0 = 1'b0, extTrig1 = 1'b0, busy = 1'b0;
  logic [2:0]  trigMode = 3'd7;
  logic [6:0]  majThresh = '0;
  logic [32:0] tickPeriod = 33'd10;
  logic        trigPulse;
  logic [31:0] trigId;
  logic [55:0] trigStamp;
  logic [15:0] overrunCnt;

  int tests = 0, fails = 0, accepted = 0;

  always #2 clk = ~clk;

  trig_gen dut (
    .clk(clk), .rstN(rstN), .chanHit(chanHit), .extTrig0(extTrig0), .extTrig1(extTrig1),
    .busy(busy), .trigMode(trigMode), .majThresh(majThresh), .tickPeriod(tickPeriod),
    .trigPulse(trigPulse), .trigId(trigId), .trigStamp(trigStamp), .overrunCnt(overrunCnt)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [6:0]  thr;
    logic [63:0] chan;
    logic        e0;
    logic        e1;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 7'd0,  64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b1, 4'd2}, // R2 top channel
    '{3'd0, 7'd0,  64'h0,                   1'b1, 1'b0, 1'b0, 4'd2}, // R2 ext ignored
    '{3'd1, 7'd0,  64'h21,                  1'b0, 1'b0, 1'b0, 4'd3}, // R3 low plane only
    '{3'd1, 7'd0,  64'h0000_0001_8000_0000, 1'b0, 1'b0, 1'b1, 4'd3}, // R3 31 and 32
    '{3'd2, 7'd0,  64'h6,                   1'b0, 1'b0, 1'b0, 4'd4}, // R4 split pairs
    '{3'd2, 7'd0,  64'hC000_0000_0000_0000, 1'b0, 1'b0, 1'b1, 4'd4}, // R4 pair 62/63
    '{3'd3, 7'd3,  64'h8000_0100_0000_0001, 1'b0, 1'b0, 1'b1, 4'd5}, // R5 count equals thr
    '{3'd3, 7'd4,  64'h8000_0100_0000_0001, 1'b0, 1'b0, 1'b0, 4'd5}, // R5 one short
    '{3'd3, 7'd64, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b1, 4'd5}, // R5 full count
    '{3'd3, 7'd0,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, 4'd5}, // R5 thr zero
    '{3'd4, 7'd0,  64'h0,                   1'b1, 1'b0, 1'b1, 4'd6}, // R6 ext0
    '{3'd4, 7'd0,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b0, 4'd6}, // R6 ext1 ignored
    '{3'd5, 7'd0,  64'h0,                   1'b0, 1'b1, 1'b1, 4'd6}, // R6 ext1
    '{3'd7, 7'd0,  64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 4'd6}  // R6 off
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // watch n cycles at negedges; checks ID on every pulse (R10)
  task automatic watch(input int n, output int cnt, output int i1, output int i2,
                       output logic [55:0] s1, output logic [55:0] s2);
    cnt = 0; i1 = -1; i2 = -1; s1 = '0; s2 = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (trigPulse) begin
        check(trigId == 32'(accepted), "R10 trigId", trigId, accepted);
        if (cnt == 0) begin i1 = i; s1 = trigStamp; end
        else if (cnt == 1) begin i2 = i; s2 = trigStamp; end
        cnt++;
        accepted++;
      end
    end
  endtask

  task automatic idle(input int n);
    int c, a, b;
    logic [55:0] x, y;
    chanHit = '0; extTrig0 = 1'b0; extTrig1 = 1'b0;
    watch(n, c, a, b, x, y);
  endtask

  initial begin
    #(4 * 100000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cnt, i1, i2;
    logic [55:0] s1, s2;
    logic [15:0] ovr0;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(trigPulse == 1'b0, "R1 trigPulse", trigPulse, 0);
    check(trigId == '0, "R1 trigId", trigId, 0);
    check(trigStamp == '0, "R1 trigStamp", trigStamp, 0);
    check(overrunCnt == '0, "R1 overrunCnt", overrunCnt, 0);

    for (int v = 0; v < NV; v++) begin
      trigMode = VEC[v].mode; majThresh = VEC[v].thr;
      idle(6);
      chanHit = VEC[v].chan; extTrig0 = VEC[v].e0; extTrig1 = VEC[v].e1;
      watch(8, cnt, i1, i2, s1, s2);
      check(cnt == int'(VEC[v].exp), $sformatf("R%0d vector %0d pulses", VEC[v].req, v), cnt, VEC[v].exp);
      if (VEC[v].exp) check(i1 == 3, $sformatf("R8 vector %0d latency", v), i1, 3);
    end

    // R8: long held level, then re-arm
    trigMode = 3'd0; idle(6);
    chanHit = 64'h20;
    watch(20, cnt, i1, i2, s1, s2);
    check(cnt == 1, "R8 held level pulses", cnt, 1);
    chanHit = '0; idle(3);
    chanHit = 64'h20;
    watch(8, cnt, i1, i2, s1, s2);
    check(cnt == 1, "R8 re-armed edge", cnt, 1);

    // R9: busy refusal and overrun
    idle(6);
    ovr0 = overrunCnt;
    busy = 1'b1;
    chanHit = 64'h1;
    watch(8, cnt, i1, i2, s1, s2);
    check(cnt == 0, "R9 pulse while busy", cnt, 0);
    check(overrunCnt == ovr0 + 16'd1, "R9 overrun count", overrunCnt, ovr0 + 1);
    busy = 1'b0;
    watch(8, cnt, i1, i2, s1, s2);
    check(cnt == 0, "R9 no pulse on busy release", cnt, 0);
    idle(6);
    chanHit = 64'h1;
    watch(8, cnt, i1, i2, s1, s2);
    check(cnt == 1, "R9 accepted after busy", cnt, 1);
    check(overrunCnt == ovr0 + 16'd1, "R9 overrun held", overrunCnt, ovr0 + 1);

    // R7: periodic spacing and clamp
    tickPeriod = 33'd10; trigMode = 3'd6;
    watch(40, cnt, i1, i2, s1, s2);
    check(cnt >= 2, "R7 period 10 count", cnt, 2);
    check(i2 - i1 == 10, "R7 period 10 spacing", i2 - i1, 10);
    trigMode = 3'd7; idle(8);
    tickPeriod = 33'd2; trigMode = 3'd6;
    watch(20, cnt, i1, i2, s1, s2);
    check(i2 - i1 == 4, "R7 clamped spacing", i2 - i1, 4);
    trigMode = 3'd7; idle(8);

    // R11: timestamp rate
    tickPeriod = 33'd32; trigMode = 3'd6;
    watch(80, cnt, i1, i2, s1, s2);
    check(i2 - i1 == 32, "R11 period 32 spacing", i2 - i1, 32);
    check(s2 - s1 == 56'd10, "R11 stamp difference", s2 - s1, 10);
    trigMode = 3'd7; idle(8);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule